// File: doc/BRIEF.md
# DMA Handshake Pulse Generator

This block drives the two request strobes that one serial channel presents to an external DMA controller. One strobe asks for a byte to send and the other asks for a received byte to be fetched. It watches two status flags from the channel: transmit buffer empty and receive character available. When the enable bit for a strobe is set and its flag goes from low to high, the block pulls that strobe low for exactly three system clocks and then releases it.

Firmware sets two bits in the channel's interrupt control register, and this block receives them as two enable inputs. It also receives a mode input for interrupting on the first received character only, and a special receive condition flag. If that special condition arrives while the first-character-only mode is selected, the block holds back the receive strobe. It sets a level-sensitive receiver interrupt instead, so the processor learns that the DMA transfer has gone wrong. The interrupt stays set until the processor side pulses a clear input.

Top module: `dma_handshake_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, both strobes `tx_req_n` and `rx_req_n` read 1 and `rx_int` reads 0.
- R2: A 0-to-1 change of `tx_empty` with `tx_en`=1 drives `tx_req_n` to 0 from the clock edge that samples the new level, for exactly 3 cycles, and then back to 1. If `tx_empty` stays at 1 afterwards, no further pulse follows.
- R3: A 0-to-1 change of `rx_avail` with `rx_en`=1 produces the same 3-cycle low pulse on `rx_req_n`, provided no special condition is blocking it.
- R4: While its enable input is 0, a rising flag produces no pulse on that strobe, and the edge is not remembered.
- R5: If the enable input of a strobe drops to 0 in the middle of a pulse, that strobe reads 1 right after the next clock edge.
- R6: When `rx_special`=1 and `first_char_mode`=1 are sampled together, no receive pulse starts in that cycle, and `rx_int` reads 1 after that edge.
- R7: When `rx_special`=1 with `first_char_mode`=0, the receive pulse runs as normal and `rx_int` stays 0.
- R8: `rx_int` holds at 1 until `int_clear`=1 is sampled, and it reads 0 after that edge. If a set condition and `int_clear` are sampled in the same cycle, the set wins.
- R9: A flag that falls and rises again while a pulse is running does not extend that pulse or start a new one. A new pulse needs the pulse to have ended and the flag to have gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Enable bit for the transmit strobe |
| rx_en | input | 1 | Enable bit for the receive strobe |
| first_char_mode | input | 1 | Interrupt on first received character only |
| tx_empty | input | 1 | Transmit buffer empty flag |
| rx_avail | input | 1 | Received character available flag |
| rx_special | input | 1 | Special receive condition flag |
| int_clear | input | 1 | Clears the receiver interrupt |
| tx_req_n | output | 1 | Transmit request strobe, active low |
| rx_req_n | output | 1 | Receive request strobe, active low |
| rx_int | output | 1 | Receiver interrupt level |

## Verification
A pulse begins at the clock edge that first samples the raised flag. It stays low through that edge and the next two, and it is high again after the fourth edge. An enable or mode change takes effect at the first edge that samples it, and so does an interrupt set or clear. The bench changes every input on a falling edge. It then samples on each following falling edge and compares the sample with the cycle index counted from that stimulus: low at indices 1 to 3, and high from index 4 on. The sweep covers every combination of enable, mode and special condition for the receive strobe, and both enable values for the transmit strobe.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    localparam int LANE_TX   = 0;
    localparam int LANE_RX   = 1;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic enable;
        logic trigger;
        logic inhibit;
    } lane_ctl_t;

    typedef enum logic [0:0] {
        LANE_IDLE = 1'b0,
        LANE_BUSY = 1'b1
    } lane_state_e;

    function automatic int cnt_width(input int cycles);
        return (cycles < 2) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/dma_rise_det.sv
module dma_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/dma_pulse_lane.sv
module dma_pulse_lane
    import dma_hs_pkg::*;
#(
    parameter int PULSE_CYCLES = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_ctl_t ctl,
    output logic      req_n
);
    localparam int CW = cnt_width(PULSE_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] remain;
    lane_state_e   state;
    logic          start;

    assign state = (remain != '0) ? LANE_BUSY : LANE_IDLE;
    assign start = ctl.enable & ctl.trigger & ~ctl.inhibit & (state == LANE_IDLE);

    always_ff @(posedge clk) begin
        if (rst)                    remain <= '0;
        else if (!ctl.enable)       remain <= '0;
        else if (start)             remain <= LOAD;
        else if (state == LANE_BUSY) remain <= remain - 1'b1;
    end

    assign req_n = (state == LANE_IDLE);
endmodule

// File: rtl/dma_rx_cond.sv
module dma_rx_cond (
    input  logic clk,
    input  logic rst,
    input  logic first_char_mode,
    input  logic rx_special,
    input  logic int_clear,
    output logic inhibit,
    output logic rx_int
);
    assign inhibit = first_char_mode & rx_special;

    always_ff @(posedge clk) begin
        if (rst)            rx_int <= 1'b0;
        else if (inhibit)   rx_int <= 1'b1;
        else if (int_clear) rx_int <= 1'b0;
    end
endmodule

// File: rtl/dma_handshake_gen.sv
module dma_handshake_gen
    import dma_hs_pkg::*;
#(
    parameter int PULSE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic rx_en,
    input  logic first_char_mode,
    input  logic tx_empty,
    input  logic rx_avail,
    input  logic rx_special,
    input  logic int_clear,
    output logic tx_req_n,
    output logic rx_req_n,
    output logic rx_int
);
    logic [NUM_LANES-1:0] flag_lv;
    logic [NUM_LANES-1:0] en_lv;
    logic [NUM_LANES-1:0] inh_lv;
    logic [NUM_LANES-1:0] rise_lv;
    logic [NUM_LANES-1:0] req_lv;
    logic                 rx_inhibit;

    assign flag_lv[LANE_TX] = tx_empty;
    assign flag_lv[LANE_RX] = rx_avail;
    assign en_lv[LANE_TX]   = tx_en;
    assign en_lv[LANE_RX]   = rx_en;
    assign inh_lv[LANE_TX]  = 1'b0;
    assign inh_lv[LANE_RX]  = rx_inhibit;

    dma_rx_cond u_rxc (
        .clk             (clk),
        .rst             (rst),
        .first_char_mode (first_char_mode),
        .rx_special      (rx_special),
        .int_clear       (int_clear),
        .inhibit         (rx_inhibit),
        .rx_int          (rx_int)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_ctl_t ctl;

        dma_rise_det u_edge (
            .clk   (clk),
            .rst   (rst),
            .level (flag_lv[g]),
            .rise  (rise_lv[g])
        );

        assign ctl = '{enable: en_lv[g], trigger: rise_lv[g], inhibit: inh_lv[g]};

        dma_pulse_lane #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .req_n (req_lv[g])
        );
    end

    assign tx_req_n = req_lv[LANE_TX];
    assign rx_req_n = req_lv[LANE_RX];
endmodule

// File: rtl/dma_handshake_chk.sv
module dma_handshake_chk #(
    parameter int PULSE_CYCLES = 3
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic rx_en,
    input logic first_char_mode,
    input logic tx_empty,
    input logic rx_avail,
    input logic rx_special,
    input logic int_clear,
    input logic tx_req_n,
    input logic rx_req_n,
    input logic rx_int
);
    int tx_low_run;
    int rx_low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_low_run <= 0;
            rx_low_run <= 0;
        end else begin
            tx_low_run <= tx_req_n ? 0 : tx_low_run + 1;
            rx_low_run <= rx_req_n ? 0 : rx_low_run + 1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (tx_req_n && rx_req_n && !rx_int));

    // R2
    tx_len_chk: assert property (@(posedge clk) disable iff (rst) tx_low_run <= PULSE_CYCLES);

    // R3
    rx_len_chk: assert property (@(posedge clk) disable iff (rst) rx_low_run <= PULSE_CYCLES);

    // R2
    tx_cause_chk: assert property (@(posedge clk) disable iff (rst) $fell(tx_req_n) |-> $past(tx_empty));

    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst) !tx_req_n |-> $past(tx_en));

    // R5
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst) !rx_req_n |-> $past(rx_en));

    // R6
    rx_block_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_req_n) |-> !($past(rx_special) && $past(first_char_mode)));

    // R6
    int_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_int) |-> ($past(rx_special) && $past(first_char_mode)));

    // R8
    int_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(int_clear) && !($past(rx_special) && $past(first_char_mode))) |-> !rx_int);
endmodule

bind dma_handshake_gen dma_handshake_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .tx_en           (tx_en),
    .rx_en           (rx_en),
    .first_char_mode (first_char_mode),
    .tx_empty        (tx_empty),
    .rx_avail        (rx_avail),
    .rx_special      (rx_special),
    .int_clear       (int_clear),
    .tx_req_n        (tx_req_n),
    .rx_req_n        (rx_req_n),
    .rx_int          (rx_int)
);

// File: tb/sim_dma_handshake_gen.sv
module sim_dma_handshake_gen;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 0, rx_en = 0, first_char_mode = 0;
    logic tx_empty = 0, rx_avail = 0, rx_special = 0, int_clear = 0;
    logic tx_req_n, rx_req_n, rx_int;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_handshake_gen #(.PULSE_CYCLES(PW)) u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
        .first_char_mode(first_char_mode), .tx_empty(tx_empty),
        .rx_avail(rx_avail), .rx_special(rx_special), .int_clear(int_clear),
        .tx_req_n(tx_req_n), .rx_req_n(rx_req_n), .rx_int(rx_int)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        chk("R1 tx_req_n in reset", tx_req_n, 1'b1);
        chk("R1 rx_req_n in reset", rx_req_n, 1'b1);
        chk("R1 rx_int in reset", rx_int, 1'b0);
        rst = 0;
        tick();
        chk("R1 tx_req_n after reset", tx_req_n, 1'b1);
        chk("R1 rx_req_n after reset", rx_req_n, 1'b1);
        chk("R1 rx_int after reset", rx_int, 1'b0);

        // R2 / R4: transmit strobe with both enable values, flag held high
        for (int en = 0; en < 2; en++) begin
            tx_en = en[0];
            tick();
            tx_empty = 1;
            for (int i = 1; i <= 8; i++) begin
                tick();
                chk(en ? "R2 tx pulse" : "R4 tx disabled", tx_req_n,
                    !(en == 1 && i <= PW));
            end
            tx_empty = 0;
            tick(); tick();
        end

        // R3 / R4 / R6 / R7: receive sweep
        for (int en = 0; en < 2; en++)
            for (int fm = 0; fm < 2; fm++)
                for (int sp = 0; sp < 2; sp++) begin
                    bit blk;
                    blk = (fm == 1 && sp == 1);
                    rx_en = en[0]; first_char_mode = fm[0]; rx_special = sp[0];
                    tick();
                    rx_avail = 1;
                    for (int i = 1; i <= 6; i++) begin
                        tick();
                        chk(blk ? "R6 rx suppressed" : (sp == 1 ? "R7 rx normal" :
                            (en == 1 ? "R3 rx pulse" : "R4 rx disabled")),
                            rx_req_n, !(en == 1 && !blk && i <= PW));
                        chk(blk ? "R6 rx_int set" : "R7 rx_int idle", rx_int, blk);
                    end
                    rx_avail = 0; rx_special = 0; int_clear = 1;
                    tick();
                    chk("R8 clear", rx_int, 1'b0);
                    int_clear = 0;
                    tick();
                end

        // R8: hold, set-over-clear priority, then clear
        first_char_mode = 1; rx_special = 1;
        tick();
        rx_special = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8 hold", rx_int, 1'b1);
        end
        rx_special = 1; int_clear = 1;
        tick();
        chk("R8 set wins", rx_int, 1'b1);
        rx_special = 0;
        tick();
        chk("R8 cleared", rx_int, 1'b0);
        int_clear = 0; first_char_mode = 0;
        tick();

        // R9: flag drops and rises during pulse
        rx_en = 1;
        rx_avail = 1;
        tick(); chk("R9 pulse c1", rx_req_n, 1'b0);
        rx_avail = 0;
        tick(); chk("R9 pulse c2", rx_req_n, 1'b0);
        rx_avail = 1;
        tick(); chk("R9 pulse c3", rx_req_n, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick(); chk("R9 no retrigger", rx_req_n, 1'b1);
        end
        rx_avail = 0;
        tick();
        rx_avail = 1;
        for (int i = 1; i <= 5; i++) begin
            tick(); chk("R9 rearmed pulse", rx_req_n, !(i <= PW));
        end
        rx_avail = 0;
        tick();

        // R5: enable dropped mid-pulse
        tx_en = 1; tx_empty = 1;
        tick(); chk("R5 pulse start", tx_req_n, 1'b0);
        tx_en = 0;
        tick(); chk("R5 released", tx_req_n, 1'b1);
        tick(); chk("R5 stays high", tx_req_n, 1'b1);
        tx_empty = 0;
        rx_avail = 1;
        tick(); chk("R5 rx start", rx_req_n, 1'b0);
        rx_en = 0;
        tick(); chk("R5 rx released", rx_req_n, 1'b1);
        rx_avail = 0;
        tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule